// File: doc/BRIEF.md
# Dual-Port Pixel Demultiplexer

This block receives one pixel sample per clock, qualified by a valid flag, together with a horizontal sync input. It steers each accepted sample to one of two registered output ports. A mode input selects single-port or paired operation. In paired operation the block counts samples from the most recent sync leading edge. It delivers them two at a time, so each port carries half the input sample rate.

In single-port mode every accepted sample is forwarded to port A one clock later, and the phase-select input has no effect. In paired mode the first sample after a sync leading edge and every odd sample after it form the first half of a pair. Even samples form the second half. The phase-select input decides whether the first half goes to port A or to port B. A polarity input chooses whether a rising or a falling sync transition is the leading edge. A leading edge that arrives while a pair is half collected drops the held sample, and counting starts again.

Top module: `pix_pair_steer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `a_vld` and `b_vld` are 0 and both data outputs are 0.
- R2: With `dual_en` = 0, a sample accepted (`smp_vld` = 1) in cycle t appears on `a_data` with `a_vld` = 1 in cycle t+1. `b_vld` stays 0, and `a_vld` is 0 in the cycle after a cycle with `smp_vld` = 0.
- R3: With `dual_en` = 0, the value of `swap_first` has no effect on any output.
- R4: With `dual_en` = 1 and `swap_first` = 0, the odd-numbered samples counted from the last leading edge (1st, 3rd, ...) go to `a_data` and the even-numbered ones go to `b_data`. Both appear together, with `a_vld` = `b_vld` = 1, in the cycle after the even sample is accepted.
- R5: With `dual_en` = 1 and `swap_first` = 1, the mapping of R4 is reversed: odd-numbered samples go to `b_data` and even-numbered ones go to `a_data`. The value of `swap_first` in the cycle of the even sample decides the mapping.
- R6: Cycles with `smp_vld` = 0 are not counted as samples and produce no output strobe.
- R7: In paired mode, a leading edge that arrives while one sample of a pair is held discards the held sample, and no strobe is produced for it. The sample accepted in the edge cycle becomes sample number one.
- R8: The leading edge is the first cycle in which `hs_in` shows its active level: high when `hs_pol` = 1, low when `hs_pol` = 0. The opposite transition does not realign the count. Out of reset the active level is treated as already seen, so holding it through reset gives no edge.
- R9: `b_vld` is 1 only together with `a_vld`, and `b_vld` is never 1 in two consecutive cycles.
- R10: Leaving paired mode clears any held half pair. After `dual_en` returns to 1, the next accepted sample is sample number one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | DW | Incoming pixel sample |
| smp_vld | input | 1 | Sample valid qualifier |
| hs_in | input | 1 | Horizontal sync |
| hs_pol | input | 1 | Sync active level: 1 = high, 0 = low |
| dual_en | input | 1 | 1 = paired two-port mode, 0 = single-port mode |
| swap_first | input | 1 | Paired mode: 1 sends the first sample of each pair to port B |
| a_data | output | DW | Port A sample |
| a_vld | output | 1 | Port A valid strobe |
| b_data | output | DW | Port B sample |
| b_vld | output | 1 | Port B valid strobe, shared pair strobe in paired mode |

## Verification
The paired path is driven with back-to-back samples, samples separated by invalid gaps, and a leading edge placed in the middle of a pair. These patterns separate correct odd/even counting from counting that advances on idle cycles or ignores realignment. The same stream is repeated with the phase select set each way, which exposes a port swap that is missing or inverted. The single-port path is run with the phase select toggling, so any influence of that input shows up. A run with the opposite sync polarity checks that only the chosen transition realigns the count, and a mode switch in the middle of a pair checks that the held half is cleared.

// File: rtl/pix_steer_pkg.sv
package pix_steer_pkg;

    // Position within a pair in paired mode
    typedef enum logic {
        SLOT_FIRST  = 1'b0,
        SLOT_SECOND = 1'b1
    } slot_e;

    // Level reported for the sync input before any sample is seen
    localparam logic ACT_RESET_LEVEL = 1'b1;

    // Convert raw sync to "active" level under the chosen polarity
    function automatic logic sync_active(input logic hs, input logic pol);
        return pol ? hs : ~hs;
    endfunction

    // True when the older sample of a pair belongs on port B
    function automatic logic older_to_b(input logic swap);
        return swap;
    endfunction

endpackage

// File: rtl/hs_lead_det.sv
module hs_lead_det
    import pix_steer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hs_in,
    input  logic hs_pol,
    output logic lead
);
    logic act;
    logic act_q;

    assign act = sync_active(hs_in, hs_pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= ACT_RESET_LEVEL;
        end else begin
            act_q <= act;
        end
    end

    assign lead = act & ~act_q;
endmodule

// File: rtl/pair_gather.sv
module pair_gather
    import pix_steer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dual_en,
    input  logic          lead,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_data,
    output logic          pair_done,
    output logic [DW-1:0] held_data
);
    slot_e slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= SLOT_FIRST;
            held_data <= '0;
        end else if (!dual_en) begin
            slot <= SLOT_FIRST;
        end else if (lead) begin
            if (smp_vld) begin
                held_data <= smp_data;
                slot      <= SLOT_SECOND;
            end else begin
                slot <= SLOT_FIRST;
            end
        end else if (smp_vld) begin
            if (slot == SLOT_FIRST) begin
                held_data <= smp_data;
                slot      <= SLOT_SECOND;
            end else begin
                slot <= SLOT_FIRST;
            end
        end
    end

    assign pair_done = dual_en & smp_vld & ~lead & (slot == SLOT_SECOND);
endmodule

// File: rtl/port_drive.sv
module port_drive
    import pix_steer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dual_en,
    input  logic          swap_first,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_data,
    input  logic          pair_done,
    input  logic [DW-1:0] held_data,
    output logic [DW-1:0] a_data,
    output logic          a_vld,
    output logic [DW-1:0] b_data,
    output logic          b_vld
);
    logic old_b;

    assign old_b = older_to_b(swap_first);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_data <= '0;
            b_data <= '0;
            a_vld  <= 1'b0;
            b_vld  <= 1'b0;
        end else begin
            a_vld <= 1'b0;
            b_vld <= 1'b0;
            if (!dual_en) begin
                if (smp_vld) begin
                    a_data <= smp_data;
                    a_vld  <= 1'b1;
                end
            end else if (pair_done) begin
                a_data <= old_b ? smp_data  : held_data;
                b_data <= old_b ? held_data : smp_data;
                a_vld  <= 1'b1;
                b_vld  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pix_pair_steer.sv
module pix_pair_steer
    import pix_steer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] smp_data,
    input  logic          smp_vld,
    input  logic          hs_in,
    input  logic          hs_pol,
    input  logic          dual_en,
    input  logic          swap_first,
    output logic [DW-1:0] a_data,
    output logic          a_vld,
    output logic [DW-1:0] b_data,
    output logic          b_vld
);
    logic          lead;
    logic          pair_done;
    logic [DW-1:0] held_data;

    hs_lead_det u_lead (
        .clk    (clk),
        .rst    (rst),
        .hs_in  (hs_in),
        .hs_pol (hs_pol),
        .lead   (lead)
    );

    pair_gather #(.DW(DW)) u_gather (
        .clk       (clk),
        .rst       (rst),
        .dual_en   (dual_en),
        .lead      (lead),
        .smp_vld   (smp_vld),
        .smp_data  (smp_data),
        .pair_done (pair_done),
        .held_data (held_data)
    );

    port_drive #(.DW(DW)) u_drive (
        .clk        (clk),
        .rst        (rst),
        .dual_en    (dual_en),
        .swap_first (swap_first),
        .smp_vld    (smp_vld),
        .smp_data   (smp_data),
        .pair_done  (pair_done),
        .held_data  (held_data),
        .a_data     (a_data),
        .a_vld      (a_vld),
        .b_data     (b_data),
        .b_vld      (b_vld)
    );
endmodule

// File: rtl/pix_pair_steer_chk.sv
module pix_pair_steer_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] smp_data,
    input logic          smp_vld,
    input logic          dual_en,
    input logic          swap_first,
    input logic [DW-1:0] a_data,
    input logic          a_vld,
    input logic [DW-1:0] b_data,
    input logic          b_vld
);
    // R1
    post_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!a_vld && !b_vld));

    // R2
    single_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (!dual_en && smp_vld) |=> (a_vld && !b_vld && a_data == $past(smp_data)));

    // R6
    single_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!dual_en && !smp_vld) |=> !a_vld);

    // R4
    pair_even_to_b_chk: assert property (@(posedge clk) disable iff (rst)
        (b_vld && !$past(swap_first)) |-> (b_data == $past(smp_data)));

    // R5
    pair_even_to_a_chk: assert property (@(posedge clk) disable iff (rst)
        (b_vld && $past(swap_first)) |-> (a_data == $past(smp_data)));

    // R9
    pair_strobe_shared_chk: assert property (@(posedge clk) disable iff (rst)
        b_vld |-> a_vld);

    // R9
    pair_rate_half_chk: assert property (@(posedge clk) disable iff (rst)
        b_vld |=> !b_vld);
endmodule

bind pix_pair_steer pix_pair_steer_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_data   (smp_data),
    .smp_vld    (smp_vld),
    .dual_en    (dual_en),
    .swap_first (swap_first),
    .a_data     (a_data),
    .a_vld      (a_vld),
    .b_data     (b_data),
    .b_vld      (b_vld)
);

// File: tb/sim_pix_pair_steer.sv
module sim_pix_pair_steer;
    localparam int DW = 8;
    localparam int NV = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] smp_data = '0;
    logic          smp_vld = 1'b0;
    logic          hs_in = 1'b0;
    logic          hs_pol = 1'b1;
    logic          dual_en = 1'b1;
    logic          swap_first = 1'b0;
    logic [DW-1:0] a_data, b_data;
    logic          a_vld, b_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pix_pair_steer #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .smp_data(smp_data), .smp_vld(smp_vld),
        .hs_in(hs_in), .hs_pol(hs_pol), .dual_en(dual_en), .swap_first(swap_first),
        .a_data(a_data), .a_vld(a_vld), .b_data(b_data), .b_vld(b_vld)
    );

    // {hs, vld, dual, swap, data, exp_av, exp_a, exp_bv, exp_b}
    localparam logic [29:0] VEC [NV] = '{
        {1'b0,1'b1,1'b1,1'b0,8'h11, 1'b0,8'h00,1'b0,8'h00}, // R4 first
        {1'b0,1'b1,1'b1,1'b0,8'h12, 1'b1,8'h11,1'b1,8'h12}, // R4 pair
        {1'b1,1'b1,1'b1,1'b0,8'h21, 1'b0,8'h00,1'b0,8'h00}, // R8 rising edge, sample one
        {1'b1,1'b1,1'b1,1'b0,8'h22, 1'b1,8'h21,1'b1,8'h22}, // R4
        {1'b1,1'b0,1'b1,1'b0,8'h99, 1'b0,8'h00,1'b0,8'h00}, // R6 gap
        {1'b1,1'b1,1'b1,1'b0,8'h23, 1'b0,8'h00,1'b0,8'h00}, // R6 first after gap
        {1'b0,1'b0,1'b1,1'b0,8'h98, 1'b0,8'h00,1'b0,8'h00}, // R8 falling edge ignored
        {1'b1,1'b1,1'b1,1'b0,8'h31, 1'b0,8'h00,1'b0,8'h00}, // R7 edge drops 23
        {1'b1,1'b1,1'b1,1'b0,8'h32, 1'b1,8'h31,1'b1,8'h32}, // R7
        {1'b0,1'b1,1'b1,1'b1,8'h41, 1'b0,8'h00,1'b0,8'h00}, // R5 first
        {1'b0,1'b1,1'b1,1'b1,8'h42, 1'b1,8'h42,1'b1,8'h41}, // R5 swapped
        {1'b1,1'b1,1'b1,1'b1,8'h51, 1'b0,8'h00,1'b0,8'h00}, // R5 edge
        {1'b1,1'b1,1'b1,1'b1,8'h52, 1'b1,8'h52,1'b1,8'h51}, // R5
        {1'b1,1'b1,1'b0,1'b0,8'h61, 1'b1,8'h61,1'b0,8'h00}, // R2
        {1'b1,1'b1,1'b0,1'b1,8'h62, 1'b1,8'h62,1'b0,8'h00}, // R3 swap ignored
        {1'b1,1'b0,1'b0,1'b1,8'h97, 1'b0,8'h00,1'b0,8'h00}, // R2 R6 idle
        {1'b1,1'b1,1'b0,1'b0,8'h63, 1'b1,8'h63,1'b0,8'h00}, // R2
        {1'b1,1'b1,1'b1,1'b0,8'h71, 1'b0,8'h00,1'b0,8'h00}, // R10 first
        {1'b1,1'b1,1'b1,1'b0,8'h72, 1'b1,8'h71,1'b1,8'h72}  // R10 pair
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic h, input logic v, input logic d,
                         input logic s, input logic [DW-1:0] x);
        hs_in = h; smp_vld = v; dual_en = d; swap_first = s; smp_data = x;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input logic eav, input logic [DW-1:0] ea,
                              input logic ebv, input logic [DW-1:0] eb, input string tag);
        check(a_vld == eav, {tag, " a_vld"}, a_vld, eav);
        check(b_vld == ebv, {tag, " b_vld"}, b_vld, ebv);
        if (eav) check(a_data == ea, {tag, " a_data"}, a_data, ea);
        if (ebv) check(b_data == eb, {tag, " b_data"}, b_data, eb);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        step();
        step();
        check(!a_vld && !b_vld, "R1 strobes in reset", {a_vld, b_vld}, 0);
        check(a_data == 0 && b_data == 0, "R1 data in reset", {a_data, b_data}, 0);
        rst = 1'b0;
        step();
        check(!a_vld && !b_vld, "R1 strobes after reset", {a_vld, b_vld}, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25:18]);
            step();
            expect_out(VEC[i][17], VEC[i][16:9], VEC[i][8], VEC[i][7:0],
                       $sformatf("R2-R10 table row %0d", i));
        end

        // R10: leave paired mode with a half pair held
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hA1); step();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00); step();
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hA2); step();
        expect_out(1'b0, 8'h00, 1'b0, 8'h00, "R10 held half cleared");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hA3); step();
        expect_out(1'b1, 8'hA2, 1'b1, 8'hA3, "R10 recount");

        // R8: low-active sync, held active through reset
        hs_pol = 1'b0;
        drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        rst = 1'b1; step(); rst = 1'b0;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h81); step();
        expect_out(1'b0, 8'h00, 1'b0, 8'h00, "R8 no edge out of reset");
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h82); step();
        expect_out(1'b1, 8'h81, 1'b1, 8'h82, "R8 pair without edge");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h83); step();
        expect_out(1'b0, 8'h00, 1'b0, 8'h00, "R8 rising not leading");
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h84); step();
        expect_out(1'b0, 8'h00, 1'b0, 8'h00, "R7 R8 falling drops held");
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h85); step();
        expect_out(1'b1, 8'h84, 1'b1, 8'h85, "R8 falling realigns");
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h86); step();
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h87); step();
        expect_out(1'b1, 8'h86, 1'b1, 8'h87, "R8 rising keeps count");

        // R7: edge with no sample leaves count at zero
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h88); step();
        drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00); step();
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h89); step();
        expect_out(1'b0, 8'h00, 1'b0, 8'h00, "R7 empty edge restarts");
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h8A); step();
        expect_out(1'b1, 8'h89, 1'b1, 8'h8A, "R7 pair after empty edge");

        drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00); step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule